// File: doc/BRIEF.md
# Signature-Addressed Store-to-Load Bypass Buffer

This block lets a store hand its data to a later load without an effective address ever being computed. Every architectural register carries a small colour tag, and each write to a register gives it a fresh colour. A memory operation is identified by its signature: the current colour of its base register, concatenated with its displacement field. Two operations with equal signatures name the same location. Because the signature needs only a colour table read, it is ready early in the pipeline.

Stores deposit their data in an 8-entry fully associative buffer under their signature. Loads search the buffer by signature in the same cycle and return a hit with data, or a miss, in which case the load continues down the normal memory path. Colours come from one global 6-bit counter. Before a colour value is handed out again after the counter wraps, every entry tagged with that value is dropped.

Top module: `sigbuf_top`

## Requirements
- R1: After reset no entry is valid, so every load misses, and every register holds colour 0, so a store through one register and a load through another register with the same displacement share a signature.
- R2: A store followed in a later cycle by a load with the same base register and displacement, with no write to that register in between, gives ld_hit=1 and the stored data.
- R3: A load whose displacement differs from every stored entry, or whose base register colour differs, gives ld_hit=0.
- R4: A write on the register-write port gives that register a new colour, so a load through it no longer matches stores made before the write. Entries stored through other registers are not affected.
- R5: A store whose signature is already held overwrites that entry in place and takes no second entry. No two valid entries ever hold the same signature.
- R6: A store with a new signature fills the lowest-numbered invalid entry. When all 8 are valid, it replaces the entry named by a round-robin pointer, which starts at entry 0 after reset, advances by one on each such replacement, and is not moved by fills, overwrites or flush.
- R7: When a store and a load with the same signature are presented in the same cycle, the load returns ld_hit=1 with the store's data, ahead of any older entry.
- R8: A flush clears every entry in one cycle. A store presented in the flush cycle is not recorded.
- R9: The colour counter starts at 1 after reset and adds 1 (modulo 64) on each register write, and the written register takes the counter value. When a colour is issued, every entry tagged with it is dropped, and a store in that same cycle whose base register holds that colour is not recorded.
- R10: The lookup is combinational: ld_hit and ld_data follow the load inputs in the same cycle, and ld_hit is 0 whenever ld_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all buffer entries |
| rw_valid | input | 1 | A register is written this cycle |
| rw_reg | input | 5 | Index of the written register |
| st_valid | input | 1 | A store is presented this cycle |
| st_base | input | 5 | Store base register index |
| st_disp | input | 12 | Store displacement field |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | A load lookup is presented this cycle |
| ld_base | input | 5 | Load base register index |
| ld_disp | input | 12 | Load displacement field |
| ld_hit | output | 1 | Load found its signature |
| ld_data | output | 32 | Data for a hitting load |

## Verification
Every cycle the checker confirms that no two valid entries answer one lookup, that the valid count grows by at most one per cycle, that a flush leaves the buffer empty, that each register write steps the colour counter by one, and that same-cycle forwarding and the idle-miss rule hold. Which entry a full buffer gives up, that an overwrite keeps the other seven entries alive, that a renamed register stops matching, and that a colour reused after 64 writes finds no stale entry can only be shown by the bench's store and load sequences.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;

  localparam int SB_NUM_REGS = 32;
  localparam int SB_COLOR_W  = 6;
  localparam int SB_DISP_W   = 12;
  localparam int SB_DATA_W   = 32;
  localparam int SB_ENTRIES  = 8;

  typedef enum logic [1:0] {
    ALLOC_NONE  = 2'd0,
    ALLOC_HIT   = 2'd1,
    ALLOC_FREE  = 2'd2,
    ALLOC_EVICT = 2'd3
  } alloc_kind_e;

endpackage

// File: rtl/sigbuf_colour_map.sv
module sigbuf_colour_map #(
  parameter int NUM_REGS = 32,
  parameter int COLOR_W  = 6,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rw_valid,
  input  logic [REG_W-1:0]   rw_reg,
  input  logic [REG_W-1:0]   rd_a_reg,
  output logic [COLOR_W-1:0] rd_a_colour,
  input  logic [REG_W-1:0]   rd_b_reg,
  output logic [COLOR_W-1:0] rd_b_colour,
  output logic               reuse_valid,
  output logic [COLOR_W-1:0] reuse_colour
);

  logic [COLOR_W-1:0] colour_q [NUM_REGS];
  logic [COLOR_W-1:0] ctr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= COLOR_W'(1);
      for (int i = 0; i < NUM_REGS; i++) colour_q[i] <= '0;
    end else if (rw_valid) begin
      colour_q[rw_reg] <= ctr_q;
      ctr_q            <= ctr_q + COLOR_W'(1);
    end
  end

  assign rd_a_colour  = colour_q[rd_a_reg];
  assign rd_b_colour  = colour_q[rd_b_reg];
  assign reuse_valid  = rw_valid;
  assign reuse_colour = ctr_q;

endmodule

// File: rtl/sigbuf_victim.sv
module sigbuf_victim
  import sigbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic               take,
  output alloc_kind_e        kind,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    if (|hit_vec) begin
      kind = ALLOC_HIT;
      idx  = hit_idx;
    end else if (!(&valid)) begin
      kind = ALLOC_FREE;
      idx  = free_idx;
    end else begin
      kind = ALLOC_EVICT;
      idx  = rr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && kind == ALLOC_EVICT) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/sigbuf_entries.sv
module sigbuf_entries
  import sigbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int COLOR_W = 6,
  parameter int DISP_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      reuse_valid,
  input  logic [COLOR_W-1:0]        reuse_colour,
  input  logic                      st_valid,
  input  logic [COLOR_W+DISP_W-1:0] st_sig,
  input  logic [DATA_W-1:0]         st_data,
  input  logic                      ld_valid,
  input  logic [COLOR_W+DISP_W-1:0] ld_sig,
  output logic                      ld_hit,
  output logic [DATA_W-1:0]         ld_data,
  output logic [ENTRIES-1:0]        valid_o,
  output logic [ENTRIES-1:0]        ld_match_o
);

  localparam int SIG_W = COLOR_W + DISP_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [SIG_W-1:0]   sig_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] st_match;
  logic [ENTRIES-1:0] ld_match;
  logic [ENTRIES-1:0] kill;
  logic               st_colour_retired;
  logic               st_take;
  logic               fwd;
  alloc_kind_e        alloc_kind;
  logic [IDX_W-1:0]   alloc_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign st_match[g] = valid_q[g] && (sig_q[g] == st_sig);
    assign ld_match[g] = valid_q[g] && (sig_q[g] == ld_sig);
    assign kill[g]     = valid_q[g] && (sig_q[g][SIG_W-1 -: COLOR_W] == reuse_colour);
  end

  assign st_colour_retired = reuse_valid && (st_sig[SIG_W-1 -: COLOR_W] == reuse_colour);
  assign st_take           = st_valid && !flush && !st_colour_retired;

  sigbuf_victim #(
    .ENTRIES (ENTRIES)
  ) victim_i (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid_q),
    .hit_vec (st_match),
    .take    (st_take),
    .kind    (alloc_kind),
    .idx     (alloc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      if (reuse_valid) valid_q <= valid_q & ~kill;
      if (st_take && alloc_kind != ALLOC_NONE) valid_q[alloc_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_take) begin
      sig_q[alloc_idx]  <= st_sig;
      data_q[alloc_idx] <= st_data;
    end
  end

  assign fwd = ld_valid && st_valid && (ld_sig == st_sig);

  always_comb begin
    ld_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (ld_match[i]) ld_data = data_q[i];
    if (fwd) ld_data = st_data;
  end

  assign ld_hit     = ld_valid && (fwd || (|ld_match));
  assign valid_o    = valid_q;
  assign ld_match_o = ld_match;

endmodule

// File: rtl/sigbuf_top.sv
module sigbuf_top
  import sigbuf_pkg::*;
#(
  parameter int NUM_REGS = SB_NUM_REGS,
  parameter int COLOR_W  = SB_COLOR_W,
  parameter int DISP_W   = SB_DISP_W,
  parameter int DATA_W   = SB_DATA_W,
  parameter int ENTRIES  = SB_ENTRIES,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rw_valid,
  input  logic [REG_W-1:0]  rw_reg,
  input  logic              st_valid,
  input  logic [REG_W-1:0]  st_base,
  input  logic [DISP_W-1:0] st_disp,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_base,
  input  logic [DISP_W-1:0] ld_disp,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data
);

  localparam int SIG_W = COLOR_W + DISP_W;

  logic [COLOR_W-1:0] st_colour;
  logic [COLOR_W-1:0] ld_colour;
  logic               reuse_valid;
  logic [COLOR_W-1:0] issue_colour;
  logic [SIG_W-1:0]   st_sig;
  logic [SIG_W-1:0]   ld_sig;
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_ld_match;

  sigbuf_colour_map #(
    .NUM_REGS (NUM_REGS),
    .COLOR_W  (COLOR_W)
  ) colour_i (
    .clk          (clk),
    .rst          (rst),
    .rw_valid     (rw_valid),
    .rw_reg       (rw_reg),
    .rd_a_reg     (st_base),
    .rd_a_colour  (st_colour),
    .rd_b_reg     (ld_base),
    .rd_b_colour  (ld_colour),
    .reuse_valid  (reuse_valid),
    .reuse_colour (issue_colour)
  );

  assign st_sig = {st_colour, st_disp};
  assign ld_sig = {ld_colour, ld_disp};

  sigbuf_entries #(
    .ENTRIES (ENTRIES),
    .COLOR_W (COLOR_W),
    .DISP_W  (DISP_W),
    .DATA_W  (DATA_W)
  ) entries_i (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .reuse_valid  (reuse_valid),
    .reuse_colour (issue_colour),
    .st_valid     (st_valid),
    .st_sig       (st_sig),
    .st_data      (st_data),
    .ld_valid     (ld_valid),
    .ld_sig       (ld_sig),
    .ld_hit       (ld_hit),
    .ld_data      (ld_data),
    .valid_o      (ent_valid),
    .ld_match_o   (ent_ld_match)
  );

endmodule

// File: rtl/sigbuf_chk.sv
module sigbuf_chk #(
  parameter int ENTRIES = 8,
  parameter int COLOR_W = 6,
  parameter int SIG_W   = 18,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               rw_valid,
  input logic               st_valid,
  input logic               ld_valid,
  input logic [SIG_W-1:0]   st_sig,
  input logic [SIG_W-1:0]   ld_sig,
  input logic [DATA_W-1:0]  st_data,
  input logic               ld_hit,
  input logic [DATA_W-1:0]  ld_data,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_ld_match,
  input logic [COLOR_W-1:0] issue_colour
);

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |-> !ld_hit); // R10

  AST_SAME_CYCLE_FWD: assert property (@(posedge clk) disable iff (rst)
    (st_valid && ld_valid && st_sig == ld_sig) |-> (ld_hit && ld_data == st_data)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0)); // R8

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ent_ld_match)); // R5

  AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ($countones(ent_valid) <= $countones($past(ent_valid)) + 1)); // R6

  AST_COLOUR_STEP: assert property (@(posedge clk) disable iff (rst)
    rw_valid |=> (issue_colour == COLOR_W'($past(issue_colour) + COLOR_W'(1)))); // R9

  AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rw_valid |=> $stable(issue_colour)); // R9

endmodule

bind sigbuf_top sigbuf_chk #(
  .ENTRIES (ENTRIES),
  .COLOR_W (COLOR_W),
  .SIG_W   (COLOR_W + DISP_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .rw_valid     (rw_valid),
  .st_valid     (st_valid),
  .ld_valid     (ld_valid),
  .st_sig       (st_sig),
  .ld_sig       (ld_sig),
  .st_data      (st_data),
  .ld_hit       (ld_hit),
  .ld_data      (ld_data),
  .ent_valid    (ent_valid),
  .ent_ld_match (ent_ld_match),
  .issue_colour (issue_colour)
);

// File: tb/sigbuf_top_tb_top.sv
module sigbuf_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        rw_valid = 1'b0;
  logic [4:0]  rw_reg = '0;
  logic        st_valid = 1'b0;
  logic [4:0]  st_base = '0;
  logic [11:0] st_disp = '0;
  logic [31:0] st_data = '0;
  logic        ld_valid = 1'b0;
  logic [4:0]  ld_base = '0;
  logic [11:0] ld_disp = '0;
  logic        ld_hit;
  logic [31:0] ld_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [5:0] mctr;

  always #4 clk = ~clk;

  sigbuf_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .rw_valid (rw_valid),
    .rw_reg   (rw_reg),
    .st_valid (st_valid),
    .st_base  (st_base),
    .st_disp  (st_disp),
    .st_data  (st_data),
    .ld_valid (ld_valid),
    .ld_base  (ld_base),
    .ld_disp  (ld_disp),
    .ld_hit   (ld_hit),
    .ld_data  (ld_data)
  );

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_LD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  rg;
    logic [11:0] disp;
    logic [31:0] data;
    logic        hit;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{OP_LD, 5'd3, 12'd10, 32'h0,        1'b0}, // R1 empty after reset
    '{OP_ST, 5'd3, 12'd10, 32'hA1A1_0001, 1'b0},
    '{OP_LD, 5'd3, 12'd10, 32'hA1A1_0001, 1'b1}, // R2
    '{OP_LD, 5'd7, 12'd10, 32'hA1A1_0001, 1'b1}, // R1 all colours 0
    '{OP_LD, 5'd3, 12'd11, 32'h0,        1'b0}, // R3 other disp
    '{OP_WR, 5'd3, 12'd0,  32'h0,        1'b0},
    '{OP_LD, 5'd3, 12'd10, 32'h0,        1'b0}, // R4 renamed
    '{OP_LD, 5'd7, 12'd10, 32'hA1A1_0001, 1'b1}, // R4 other reg kept
    '{OP_ST, 5'd3, 12'd10, 32'hB2B2_0002, 1'b0},
    '{OP_LD, 5'd3, 12'd10, 32'hB2B2_0002, 1'b1}, // R2
    '{OP_ST, 5'd3, 12'd10, 32'hC3C3_0003, 1'b0},
    '{OP_LD, 5'd3, 12'd10, 32'hC3C3_0003, 1'b1}, // R5 overwrite
    '{OP_LD, 5'd7, 12'd10, 32'hA1A1_0001, 1'b1}  // R3 colours separate
  };

  task automatic step(input logic w, input logic [4:0] wr,
                      input logic s, input logic [4:0] sb, input logic [11:0] sd,
                      input logic [31:0] sdat,
                      input logic l, input logic [4:0] lb, input logic [11:0] ldd,
                      input logic f);
    @(negedge clk);
    rw_valid = w;  rw_reg = wr;
    st_valid = s;  st_base = sb; st_disp = sd; st_data = sdat;
    ld_valid = l;  ld_base = lb; ld_disp = ldd;
    flush = f;
    #2;
    if (w) mctr = mctr + 6'd1;
  endtask

  task automatic check(input string req, input logic exp_hit, input logic [31:0] exp_data);
    total++;
    if (ld_hit !== exp_hit || (exp_hit && ld_data !== exp_data)) begin
      bad++;
      $display("FAIL %s: actual hit=%0b data=%h expected hit=%0b data=%h",
               req, ld_hit, ld_data, exp_hit, exp_data);
    end
  endtask

  task automatic probe(input string req, input logic [4:0] b, input logic [11:0] d,
                       input logic exp_hit, input logic [31:0] exp_data);
    step(1'b0, 5'd0, 1'b0, 5'd0, 12'd0, 32'd0, 1'b1, b, d, 1'b0);
    check(req, exp_hit, exp_data);
  endtask

  task automatic store(input logic [4:0] b, input logic [11:0] d, input logic [31:0] v);
    step(1'b0, 5'd0, 1'b1, b, d, v, 1'b0, 5'd0, 12'd0, 1'b0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    rw_valid = 1'b0; st_valid = 1'b0; ld_valid = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mctr = 6'd1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1-all: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply_reset();

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR: step(1'b1, VECS[i].rg, 1'b0, 5'd0, 12'd0, 32'd0, 1'b0, 5'd0, 12'd0, 1'b0);
        OP_ST: store(VECS[i].rg, VECS[i].disp, VECS[i].data);
        default: begin
          probe($sformatf("vector %0d (R1 R2 R3 R4 R5)", i), VECS[i].rg, VECS[i].disp,
                VECS[i].hit, VECS[i].data);
        end
      endcase
    end

    // R10: matching signature but no load request
    step(1'b0, 5'd0, 1'b0, 5'd0, 12'd0, 32'd0, 1'b0, 5'd7, 12'd10, 1'b0);
    check("R10 idle lookup", 1'b0, 32'd0);

    // R8: flush with a store in the same cycle
    step(1'b0, 5'd0, 1'b1, 5'd7, 12'd20, 32'hDEAD_0020, 1'b0, 5'd0, 12'd0, 1'b1);
    probe("R8 old entry flushed", 5'd7, 12'd10, 1'b0, 32'd0);
    probe("R8 flush-cycle store dropped", 5'd7, 12'd20, 1'b0, 32'd0);

    // R6: fill all 8 entries, overwrite in place, then round-robin eviction
    for (int i = 0; i < 8; i++) store(5'd5, 12'(i), 32'h100 + i);
    store(5'd5, 12'd3, 32'h0333_0333);
    for (int i = 0; i < 8; i++)
      probe("R5 overwrite keeps all entries", 5'd5, 12'(i), 1'b1,
            (i == 3) ? 32'h0333_0333 : 32'h100 + i);
    store(5'd5, 12'd8, 32'h108);
    probe("R6 first eviction takes entry 0", 5'd5, 12'd0, 1'b0, 32'd0);
    probe("R6 new entry present", 5'd5, 12'd8, 1'b1, 32'h108);
    probe("R6 entry 1 kept", 5'd5, 12'd1, 1'b1, 32'h101);
    store(5'd5, 12'd9, 32'h109);
    probe("R6 second eviction takes entry 1", 5'd5, 12'd1, 1'b0, 32'd0);
    probe("R6 entry 2 kept", 5'd5, 12'd2, 1'b1, 32'h102);

    // R7: same-cycle store and load forwarding
    step(1'b0, 5'd0, 1'b1, 5'd6, 12'd50, 32'h5050_0001, 1'b1, 5'd6, 12'd50, 1'b0);
    check("R7 forward new signature", 1'b1, 32'h5050_0001);
    step(1'b0, 5'd0, 1'b1, 5'd6, 12'd50, 32'h5050_0002, 1'b1, 5'd6, 12'd50, 1'b0);
    check("R7 forward beats older entry", 1'b1, 32'h5050_0002);
    probe("R7 stored after forward", 5'd6, 12'd50, 1'b1, 32'h5050_0002);

    // R9: colour wrap invalidates entries tagged with the reissued colour
    step(1'b0, 5'd0, 1'b0, 5'd0, 12'd0, 32'd0, 1'b0, 5'd0, 12'd0, 1'b1);
    store(5'd1, 12'd5, 32'h0000_5151);
    while (mctr != 6'd0)
      step(1'b1, 5'd2, 1'b0, 5'd0, 12'd0, 32'd0, 1'b0, 5'd0, 12'd0, 1'b0);
    probe("R9 entry alive before reuse", 5'd1, 12'd5, 1'b1, 32'h0000_5151);
    step(1'b1, 5'd2, 1'b1, 5'd4, 12'd6, 32'h0000_6464, 1'b0, 5'd0, 12'd0, 1'b0);
    probe("R9 reused colour entry dropped", 5'd1, 12'd5, 1'b0, 32'd0);
    probe("R9 new holder sees no stale data", 5'd2, 12'd5, 1'b0, 32'd0);
    probe("R9 store on retiring colour dropped", 5'd4, 12'd6, 1'b0, 32'd0);

    // R1: reset empties the buffer again
    store(5'd9, 12'd77, 32'h7777_7777);
    probe("R2 store before reset", 5'd9, 12'd77, 1'b1, 32'h7777_7777);
    apply_reset();
    probe("R1 empty after second reset", 5'd9, 12'd77, 1'b0, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule